// File: doc/BRIEF.md
# Multi-Channel PWM Timer Bank

This block holds a bank of independent 16-bit timer channels, up to eight of them, behind a small word-addressed register interface. Each channel counts prescaled ticks from one of three clock sources. It raises a flag at a programmable mid-point and another when it reaches its period value, where it wraps to zero. It can also drive a pulse-width output that is active from the start of each period until the mid-point.

Four global words are shared by all channels. One holds the run enables, one holds the stop bits, one holds the pending flags and one holds the interrupt masks. Each word has one address that loads the whole word, one that only sets bits and one that only clears bits, so software can change a single channel without a read-modify-write. The interrupt line is the OR of every pending flag whose mask bit is clear. When a pulse-width channel is disabled, it either drops its output at once or finishes its current period first, as chosen per channel.

The slow and external clock sources arrive as single-cycle enables that are already synchronous to `clk`. Reads are combinational from `busAddr`.

Top module: `pwm_timer_bank`

## Requirements
- R1: Every global word has a load address, a set address and a clear address. Enable: 0x00 load, 0x04 set, 0x08 clear. Stop: 0x0C load, 0x1C set, 0x2C clear. Flags: 0x10 load, 0x14 set, 0x18 clear. Mask: 0x20 load, 0x24 set, 0x28 clear. Through a set or clear address, 1 bits act and 0 bits leave the word unchanged. The set and clear addresses read as zero.
- R2: Channel n has four registers starting at 0x30 + 0x10·n. Offset +0 is the period value, +4 the mid-point value, +8 the counter and +C the control word. The first three are 16 bits; the control word keeps bits [9:0]. All four read back what was written.
- R3: A channel runs while its enable bit is set and its stop bit is clear. It adds one to its counter on each prescaled tick. When the incremented value equals the period value, the counter becomes 0 and the channel's period flag (flag bit n) sets. A software write to the counter takes priority over a tick. A stopped channel holds its counter.
- R4: Control bits [5:3] divide the source by 1, 4, 16, 64, 256 or 1024 for codes 0 to 5; codes 6 and 7 also divide by 1024. With the every-cycle source, the period flag therefore sets every period × divisor cycles.
- R5: When the incremented value equals the mid-point value, the mid-point flag (flag bit n+16) sets.
- R6: Control bit 0 selects counting on every clock cycle, bit 1 selects the `rtcTick` input and bit 2 selects the `extTick` input. When several of these bits are set, the lowest-numbered one wins. With none set, the channel does not count.
- R7: `irq` is high exactly when some flag bit is set and its mask bit (same position) is clear.
- R8: Control bit 7 enables the pulse output. The output is active while the counter is below the mid-point value, and control bit 8 inverts it, making it active low. With bit 7 clear, or with the channel disabled and not finishing a period, the output sits at its inactive level.
- R9: The action when a channel's enable bit is cleared while bit 7 is set depends on control bit 9. With bit 9 set, the output goes inactive from that same edge and the counter freezes. With bit 9 clear, the channel keeps counting and driving until its next wrap, then rests at 0 with the output inactive.
- R10: After reset the enable, stop and flag words are zero, all existing mask bits are set, all channel registers are zero, `irq` is low and the pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the register accessed |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for `busAddr`, combinational |
| rtcTick | input | 1 | Slow-clock enable pulse, synchronous to clk |
| extTick | input | 1 | External-clock enable pulse, synchronous to clk |
| pwmOut | output | NUM_CH | Pulse outputs, one per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
A write takes effect at the rising edge where `busWrEn` is sampled high, so a read issued at the next falling edge already returns the new value. A channel enabled at edge E ticks first at edge E+1 with the every-cycle source. A wrap clears the counter and sets its flag at the same edge, and `irq` and `pwmOut` follow combinationally from those registers. The bench therefore drives and samples only at falling edges and counts these edges explicitly for every expected value. It measures prescaler periods as the distance between two successive period-flag rises, which does not depend on when counting began.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int MAX_CH   = 8;
  localparam int CNT_W    = 16;
  localparam int CTRL_W   = 10;
  localparam int PRE_W    = 10;
  localparam int HALF_LSB = 16;

  // control word bit positions
  localparam int SRC_PCLK   = 0;
  localparam int SRC_RTC    = 1;
  localparam int SRC_EXT    = 2;
  localparam int PRE_LSB    = 3;
  localparam int PWM_EN     = 7;
  localparam int PWM_LOW    = 8;
  localparam int PWM_ABRUPT = 9;
  localparam int MAX_DIV_SEL = 5;

  // global word addresses
  localparam int OFS_EN        = 'h00;
  localparam int OFS_EN_SET    = 'h04;
  localparam int OFS_EN_CLR    = 'h08;
  localparam int OFS_STOP      = 'h0C;
  localparam int OFS_STOP_SET  = 'h1C;
  localparam int OFS_STOP_CLR  = 'h2C;
  localparam int OFS_FLAG      = 'h10;
  localparam int OFS_FLAG_SET  = 'h14;
  localparam int OFS_FLAG_CLR  = 'h18;
  localparam int OFS_MASK      = 'h20;
  localparam int OFS_MASK_SET  = 'h24;
  localparam int OFS_MASK_CLR  = 'h28;
  localparam int CH_BASE       = 'h30;
  localparam int CH_STRIDE     = 'h10;

  typedef struct packed {
    logic [MAX_CH-1:0] fullWr;
    logic [MAX_CH-1:0] halfWr;
    logic [MAX_CH-1:0] cntWr;
    logic [MAX_CH-1:0] ctrlWr;
    logic [MAX_CH-1:0] enDrop;
    logic [CNT_W-1:0]  wrData;
  } chanStrobes_t;
endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic                             busWrEn,
  input  logic [DATA_W-1:0]                busWrData,
  output logic [DATA_W-1:0]                busRdData,
  input  logic [NUM_CH-1:0]                fullHit,
  input  logic [NUM_CH-1:0]                halfHit,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     fullVal,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     halfVal,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     cntVal,
  input  logic [NUM_CH-1:0][CTRL_W-1:0]    ctrlVal,
  output chanStrobes_t                     chanStb,
  output logic [NUM_CH-1:0]                enable,
  output logic [NUM_CH-1:0]                stop,
  output logic                             irq
);
  logic [NUM_CH-1:0] enableQ, stopQ, flagFullQ, flagHalfQ, maskFullQ, maskHalfQ;
  logic [NUM_CH-1:0] enNext, stopNext, flagFullNext, flagHalfNext, maskFullNext, maskHalfNext;
  logic [NUM_CH-1:0] loBits, hiBits;
  logic [DATA_W-1:0] rdData;
  int addrI, chanNum, regSel;
  logic inChan;
  logic unusedWrBits;

  function automatic logic [NUM_CH-1:0] applyWr(input logic [NUM_CH-1:0] cur,
                                                input logic [NUM_CH-1:0] val,
                                                input logic ld, input logic st,
                                                input logic cl);
    if (ld) return val;
    if (st) return cur | val;
    if (cl) return cur & ~val;
    return cur;
  endfunction

  assign loBits = busWrData[NUM_CH-1:0];
  assign hiBits = busWrData[HALF_LSB +: NUM_CH];
  assign unusedWrBits = ^busWrData[DATA_W-1:HALF_LSB+NUM_CH];

  always_comb begin
    addrI   = int'(busAddr);
    chanNum = (addrI - CH_BASE) / CH_STRIDE;
    regSel  = ((addrI - CH_BASE) % CH_STRIDE) / 4;
    inChan  = (addrI >= CH_BASE) && (chanNum < NUM_CH);

    enNext   = applyWr(enableQ, loBits, busWrEn && addrI == OFS_EN,
                       busWrEn && addrI == OFS_EN_SET, busWrEn && addrI == OFS_EN_CLR);
    stopNext = applyWr(stopQ, loBits, busWrEn && addrI == OFS_STOP,
                       busWrEn && addrI == OFS_STOP_SET, busWrEn && addrI == OFS_STOP_CLR);
    maskFullNext = applyWr(maskFullQ, loBits, busWrEn && addrI == OFS_MASK,
                       busWrEn && addrI == OFS_MASK_SET, busWrEn && addrI == OFS_MASK_CLR);
    maskHalfNext = applyWr(maskHalfQ, hiBits, busWrEn && addrI == OFS_MASK,
                       busWrEn && addrI == OFS_MASK_SET, busWrEn && addrI == OFS_MASK_CLR);
    // a hardware event is never lost to a clear in the same cycle
    flagFullNext = applyWr(flagFullQ, loBits, busWrEn && addrI == OFS_FLAG,
                       busWrEn && addrI == OFS_FLAG_SET, busWrEn && addrI == OFS_FLAG_CLR) | fullHit;
    flagHalfNext = applyWr(flagHalfQ, hiBits, busWrEn && addrI == OFS_FLAG,
                       busWrEn && addrI == OFS_FLAG_SET, busWrEn && addrI == OFS_FLAG_CLR) | halfHit;

    chanStb        = '0;
    chanStb.wrData = busWrData[CNT_W-1:0];
    chanStb.enDrop = MAX_CH'(enableQ & ~enNext);

    rdData = '0;
    case (addrI)
      OFS_EN:   rdData[NUM_CH-1:0] = enableQ;
      OFS_STOP: rdData[NUM_CH-1:0] = stopQ;
      OFS_FLAG: begin
        rdData[NUM_CH-1:0]          = flagFullQ;
        rdData[HALF_LSB +: NUM_CH]  = flagHalfQ;
      end
      OFS_MASK: begin
        rdData[NUM_CH-1:0]          = maskFullQ;
        rdData[HALF_LSB +: NUM_CH]  = maskHalfQ;
      end
      default: ;
    endcase

    for (int i = 0; i < NUM_CH; i++) begin
      if (inChan && chanNum == i) begin
        case (regSel)
          0: begin chanStb.fullWr[i] = busWrEn; rdData[CNT_W-1:0]  = fullVal[i]; end
          1: begin chanStb.halfWr[i] = busWrEn; rdData[CNT_W-1:0]  = halfVal[i]; end
          2: begin chanStb.cntWr[i]  = busWrEn; rdData[CNT_W-1:0]  = cntVal[i];  end
          default: begin chanStb.ctrlWr[i] = busWrEn; rdData[CTRL_W-1:0] = ctrlVal[i]; end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ   <= '0;
      stopQ     <= '0;
      flagFullQ <= '0;
      flagHalfQ <= '0;
      maskFullQ <= '1;
      maskHalfQ <= '1;
    end else begin
      enableQ   <= enNext;
      stopQ     <= stopNext;
      flagFullQ <= flagFullNext;
      flagHalfQ <= flagHalfNext;
      maskFullQ <= maskFullNext;
      maskHalfQ <= maskHalfNext;
    end
  end

  assign busRdData = rdData;
  assign enable    = enableQ;
  assign stop      = stopQ;
  assign irq       = |({flagHalfQ, flagFullQ} & ~{maskHalfQ, maskFullQ});
endmodule

// File: rtl/pwm_timer_datapath.sv
module pwm_timer_datapath
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  chanStrobes_t                  chanStb,
  input  logic [NUM_CH-1:0]             enable,
  input  logic [NUM_CH-1:0]             stop,
  input  logic                          rtcTick,
  input  logic                          extTick,
  output logic [NUM_CH-1:0]             fullHit,
  output logic [NUM_CH-1:0]             halfHit,
  output logic [NUM_CH-1:0]             pwmOut,
  output logic [NUM_CH-1:0][CNT_W-1:0]  fullVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]  halfVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cntVal,
  output logic [NUM_CH-1:0][CTRL_W-1:0] ctrlVal
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    logic [CNT_W-1:0]  fullQ, halfQ, cntQ, incVal;
    logic [CTRL_W-1:0] ctrlQ;
    logic [PRE_W-1:0]  preQ, preMask;
    logic [2:0]        divSel;
    logic srcPulse, live, run, tick, wrapNow, midNow, drainQ, pwmLevel;

    always_comb begin
      srcPulse = ctrlQ[SRC_PCLK] ? 1'b1 :
                 ctrlQ[SRC_RTC]  ? rtcTick :
                 ctrlQ[SRC_EXT]  ? extTick : 1'b0;
      divSel   = (ctrlQ[PRE_LSB +: 3] > 3'(MAX_DIV_SEL)) ? 3'(MAX_DIV_SEL) : ctrlQ[PRE_LSB +: 3];
      preMask  = PRE_W'((32'd1 << (2 * int'(divSel))) - 32'd1);
      live     = enable[n] | drainQ;
      run      = live & ~stop[n];
      tick     = run & srcPulse & ((preQ & preMask) == preMask);
      incVal   = cntQ + 1'b1;
      wrapNow  = tick & ~chanStb.cntWr[n] & (incVal == fullQ);
      midNow   = tick & ~chanStb.cntWr[n] & (incVal == halfQ);
      pwmLevel = (ctrlQ[PWM_EN] & live & (cntQ < halfQ)) ^ ctrlQ[PWM_LOW];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fullQ  <= '0;
        halfQ  <= '0;
        cntQ   <= '0;
        ctrlQ  <= '0;
        preQ   <= '0;
        drainQ <= 1'b0;
      end else begin
        if (chanStb.fullWr[n]) fullQ <= chanStb.wrData;
        if (chanStb.halfWr[n]) halfQ <= chanStb.wrData;
        if (chanStb.ctrlWr[n]) ctrlQ <= chanStb.wrData[CTRL_W-1:0];

        if (!run)          preQ <= '0;
        else if (srcPulse) preQ <= preQ + 1'b1;

        if (chanStb.cntWr[n]) cntQ <= chanStb.wrData;
        else if (tick)        cntQ <= (incVal == fullQ) ? '0 : incVal;

        if (chanStb.enDrop[n])
          drainQ <= ctrlQ[PWM_EN] & ~ctrlQ[PWM_ABRUPT] & ~wrapNow;
        else if (enable[n] || wrapNow)
          drainQ <= 1'b0;
      end
    end

    assign fullHit[n] = wrapNow;
    assign halfHit[n] = midNow;
    assign pwmOut[n]  = pwmLevel;
    assign fullVal[n] = fullQ;
    assign halfVal[n] = halfQ;
    assign cntVal[n]  = cntQ;
    assign ctrlVal[n] = ctrlQ;
  end
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              rtcTick,
  input  logic              extTick,
  output logic [NUM_CH-1:0] pwmOut,
  output logic              irq
);
  chanStrobes_t                  chanStb;
  logic [NUM_CH-1:0]             enable, stop, fullHit, halfHit;
  logic [NUM_CH-1:0][CNT_W-1:0]  fullVal, halfVal, cntVal;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrlVal;

  pwm_timer_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .fullHit(fullHit), .halfHit(halfHit), .fullVal(fullVal), .halfVal(halfVal),
    .cntVal(cntVal), .ctrlVal(ctrlVal), .chanStb(chanStb),
    .enable(enable), .stop(stop), .irq(irq)
  );

  pwm_timer_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .chanStb(chanStb), .enable(enable), .stop(stop),
    .rtcTick(rtcTick), .extTick(extTick), .fullHit(fullHit), .halfHit(halfHit),
    .pwmOut(pwmOut), .fullVal(fullVal), .halfVal(halfVal), .cntVal(cntVal),
    .ctrlVal(ctrlVal)
  );
endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_CH-1:0]             enable,
  input logic [NUM_CH-1:0]             stop,
  input logic [NUM_CH-1:0]             cntWr,
  input logic [NUM_CH-1:0]             fullHit,
  input logic [NUM_CH-1:0]             halfHit,
  input logic [NUM_CH-1:0]             pwmOut,
  input logic [NUM_CH-1:0][CNT_W-1:0]  fullVal,
  input logic [NUM_CH-1:0][CNT_W-1:0]  halfVal,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cntVal,
  input logic [NUM_CH-1:0][CTRL_W-1:0] ctrlVal
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      fullHit[n] |=> cntVal[n] == '0); // R3
    AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
      stop[n] && !cntWr[n] |=> $stable(cntVal[n])); // R3
    AST_MID_WITH_WRAP: assert property (@(posedge clk) disable iff (!rstN)
      fullHit[n] && (halfVal[n] == fullVal[n]) |-> halfHit[n]); // R5
    AST_PWM_OFF_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
      !ctrlVal[n][PWM_EN] |-> pwmOut[n] == ctrlVal[n][PWM_LOW]); // R8
    AST_ABRUPT_CUT: assert property (@(posedge clk) disable iff (!rstN)
      $fell(enable[n]) && $stable(ctrlVal[n]) && ctrlVal[n][PWM_ABRUPT]
        |-> pwmOut[n] == ctrlVal[n][PWM_LOW]); // R9
  end
endmodule

bind pwm_timer_bank pwm_timer_checker #(.NUM_CH(NUM_CH)) u_checker (
  .clk(clk), .rstN(rstN), .enable(enable), .stop(stop), .cntWr(chanStb.cntWr[NUM_CH-1:0]),
  .fullHit(fullHit), .halfHit(halfHit), .pwmOut(pwmOut), .fullVal(fullVal),
  .halfVal(halfVal), .cntVal(cntVal), .ctrlVal(ctrlVal)
);

// File: tb/test_pwm_timer_bank.sv
`timescale 1ns/1ps
module test_pwm_timer_bank;
  localparam int NCH = 2;

  logic clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0, rtcTick = 1'b0, extTick = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NCH-1:0] pwmOut;
  logic irq;
  int nChecks = 0, nFails = 0;
  longint cyc = 0;
  logic [31:0] d, d2;
  longint t1, t2;

  pwm_timer_bank #(.NUM_CH(NCH), .ADDR_W(8), .DATA_W(32)) i_pwm_timer_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .rtcTick(rtcTick),
    .extTick(extTick), .pwmOut(pwmOut), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] chReg(input int ch, input int idx);
    return 8'(8'h30 + 16 * ch + 4 * idx);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    busAddr = a; busWrData = v; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitFull0(output longint t);
    logic [31:0] v;
    do begin
      @(negedge clk);
      rd(8'h10, v);
    end while (!v[0]);
    t = cyc;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R10 reset state
    rd(8'h20, d); check("R10 mask reset", d, 32'h0003_0003);
    rd(8'h00, d); check("R10 enable reset", d, 0);
    rd(8'h10, d); check("R10 flag reset", d, 0);
    rd(chReg(1, 0), d); check("R10 period reset", d, 0);
    check("R10 irq reset", 32'(irq), 0);
    check("R10 pwm reset", 32'(pwmOut), 0);

    // R1 set/clear/load aliases
    wr(8'h04, 1); wr(8'h04, 2);
    rd(8'h00, d); check("R1 enable set", d, 3);
    rd(8'h04, d); check("R1 set alias reads zero", d, 0);
    wr(8'h08, 1); rd(8'h00, d); check("R1 enable clear", d, 2);
    wr(8'h00, 0); rd(8'h00, d); check("R1 enable load", d, 0);
    wr(8'h1C, 3); wr(8'h2C, 2); rd(8'h0C, d); check("R1 stop set/clear", d, 1);
    wr(8'h2C, 1); rd(8'h0C, d); check("R1 stop cleared", d, 0);
    wr(8'h28, 32'h0001_0001); rd(8'h20, d); check("R1 mask clear", d, 32'h0002_0002);
    wr(8'h24, 32'h0001_0001); rd(8'h20, d); check("R1 mask set", d, 32'h0003_0003);
    wr(8'h10, 32'h0001_0000); rd(8'h10, d); check("R1 flag load", d, 32'h0001_0000);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h10, d); check("R1 flag clear", d, 0);

    // R2 channel register map
    for (int ch = 0; ch < NCH; ch++) begin
      wr(chReg(ch, 0), 32'hA5A0 + ch);
      wr(chReg(ch, 1), 32'h1234 + ch);
      wr(chReg(ch, 2), 32'hBEEF - ch);
      wr(chReg(ch, 3), 32'h2A8 | (ch << 8));
      rd(chReg(ch, 0), d); check("R2 period readback", d, 32'hA5A0 + ch);
      rd(chReg(ch, 1), d); check("R2 mid readback", d, 32'h1234 + ch);
      rd(chReg(ch, 2), d); check("R2 counter readback", d, 32'hBEEF - ch);
      rd(chReg(ch, 3), d); check("R2 control readback", d, 32'h2A8 | (ch << 8));
    end
    check("R8 idle level follows polarity", 32'(pwmOut), 32'h2);
    wr(chReg(0, 3), 0); wr(chReg(1, 3), 0);

    // R4 prescaler sweep, period 3
    for (int sel = 0; sel < 8; sel++) begin
      int div;
      div = 1 << (2 * ((sel > 5) ? 5 : sel));
      wr(8'h08, 1);
      wr(chReg(0, 0), 3); wr(chReg(0, 2), 0);
      wr(chReg(0, 3), (sel << 3) | 1);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h04, 1);
      waitFull0(t1);
      wr(8'h18, 1);
      waitFull0(t2);
      check($sformatf("R4 period sel=%0d", sel), 32'(t2 - t1), 32'(3 * div));
    end
    wr(8'h08, 1);

    // R6 source selection
    wr(chReg(0, 0), 0); wr(chReg(0, 1), 0); wr(chReg(0, 2), 0);
    wr(chReg(0, 3), 32'h002); wr(8'h04, 1);
    step(5); rd(chReg(0, 2), d); check("R6 slow source idle", d, 0);
    @(negedge clk); rtcTick = 1'b1; step(3); rtcTick = 1'b0;
    rd(chReg(0, 2), d); check("R6 slow source counts", d, 3);
    extTick = 1'b1; step(4); extTick = 1'b0;
    rd(chReg(0, 2), d); check("R6 unselected ext ignored", d, 3);
    wr(chReg(0, 3), 32'h006);
    extTick = 1'b1; step(2); extTick = 1'b0;
    rd(chReg(0, 2), d); check("R6 lowest source wins, ext ignored", d, 3);
    rtcTick = 1'b1; step(2); rtcTick = 1'b0;
    rd(chReg(0, 2), d); check("R6 lowest source wins, slow counts", d, 5);
    wr(chReg(0, 3), 32'h004);
    extTick = 1'b1; step(2); extTick = 1'b0;
    rd(chReg(0, 2), d); check("R6 ext source counts", d, 7);
    wr(chReg(0, 3), 32'h007);
    rd(chReg(0, 2), d); step(1); rd(chReg(0, 2), d2);
    check("R6 clock source wins", d2 - d, 1);
    wr(chReg(0, 3), 32'h000);
    rd(chReg(0, 2), d); step(3); rd(chReg(0, 2), d2);
    check("R6 no source no count", d2, d);
    wr(8'h08, 1);

    // R3 load, wrap, stop
    wr(chReg(0, 0), 10); wr(chReg(0, 1), 0); wr(chReg(0, 2), 7);
    wr(chReg(0, 3), 1); wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h04, 1);
    rd(chReg(0, 2), d); check("R3 loaded value kept", d, 7);
    step(1); rd(chReg(0, 2), d); check("R3 increments", d, 8);
    step(2); rd(chReg(0, 2), d); check("R3 wraps to zero", d, 0);
    rd(8'h10, d); check("R3 period flag", d, 1);
    wr(8'h1C, 1);
    rd(chReg(0, 2), d); step(5); rd(chReg(0, 2), d2);
    check("R3 stop holds counter", d2, d);
    wr(8'h2C, 1);
    rd(chReg(0, 2), d2); check("R3 resume edge", d2, d);
    step(1); rd(chReg(0, 2), d2); check("R3 resumes counting", d2, d + 1);
    wr(8'h08, 1); wr(8'h18, 32'hFFFF_FFFF);

    // R5 mid-point flag on channel 1
    wr(chReg(1, 0), 6); wr(chReg(1, 1), 2); wr(chReg(1, 2), 0); wr(chReg(1, 3), 1);
    wr(8'h04, 2);
    step(1); rd(8'h10, d); check("R5 no flag before mid", d, 0);
    step(1); rd(8'h10, d); check("R5 mid flag bit n+16", d, 32'h0002_0000);
    step(4); rd(8'h10, d); check("R5 both flags after wrap", d, 32'h0002_0002);
    wr(8'h08, 2);

    // R7 interrupt masking
    check("R7 all masked", 32'(irq), 0);
    wr(8'h28, 2); check("R7 unmasked period flag", 32'(irq), 1);
    wr(8'h18, 2); check("R7 masked mid flag quiet", 32'(irq), 0);
    wr(8'h28, 32'h0002_0000); check("R7 unmasked mid flag", 32'(irq), 1);
    wr(8'h18, 32'h0002_0000); check("R7 flags cleared", 32'(irq), 0);
    wr(8'h14, 1); check("R7 set alias masked", 32'(irq), 0);
    wr(8'h28, 1); check("R7 set alias unmasked", 32'(irq), 1);
    wr(8'h18, 1); check("R7 cleared again", 32'(irq), 0);
    wr(8'h24, 32'hFFFF_FFFF);

    // R8 pulse waveform
    wr(chReg(0, 0), 8); wr(chReg(0, 1), 3); wr(chReg(0, 2), 0);
    wr(chReg(0, 3), 32'h081); wr(8'h04, 1);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); rd(chReg(0, 2), d);
      check("R8 active below mid", 32'(pwmOut[0]), 32'(d < 3));
    end
    wr(chReg(0, 3), 32'h181);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); rd(chReg(0, 2), d);
      check("R8 active low", 32'(pwmOut[0]), 32'(!(d < 3)));
    end
    wr(chReg(0, 3), 32'h001); step(2);
    check("R8 output disabled", 32'(pwmOut[0]), 0);
    wr(chReg(0, 3), 32'h101); step(2);
    check("R8 output disabled inverted", 32'(pwmOut[0]), 1);
    wr(chReg(0, 3), 32'h001); wr(8'h08, 1);

    // R9 abrupt shutdown
    wr(chReg(0, 1), 6); wr(chReg(0, 2), 0); wr(chReg(0, 3), 32'h281);
    wr(8'h04, 1);
    do begin @(negedge clk); rd(chReg(0, 2), d); end while (d != 2);
    wr(8'h08, 1);
    rd(chReg(0, 2), d); check("R9 abrupt count at stop", d, 4);
    check("R9 abrupt output off", 32'(pwmOut[0]), 0);
    step(3); rd(chReg(0, 2), d); check("R9 abrupt counter frozen", d, 4);

    // R9 graceful shutdown
    wr(chReg(0, 2), 0); wr(chReg(0, 3), 32'h081); wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h04, 1);
    do begin @(negedge clk); rd(chReg(0, 2), d); end while (d != 2);
    wr(8'h08, 1);
    rd(chReg(0, 2), d); check("R9 graceful keeps counting", d, 4);
    check("R9 graceful output held", 32'(pwmOut[0]), 1);
    step(1); rd(chReg(0, 2), d); check("R9 graceful next count", d, 5);
    check("R9 graceful output still held", 32'(pwmOut[0]), 1);
    step(3); rd(chReg(0, 2), d); check("R9 graceful ends at wrap", d, 0);
    check("R9 graceful output released", 32'(pwmOut[0]), 0);
    rd(8'h10, d); check("R9 graceful final wrap flag", d & 1, 1);
    step(4); rd(chReg(0, 2), d); check("R9 graceful rests at zero", d, 0);

    finishRun();
  end
endmodule